// File: doc/BRIEF.md
# Two-Level PWM Intensity Controller

This block produces one pulse-width-modulated enable per channel for a bank of sixteen open-drain LED current sinks. In the normal, two-level mode a coarse level shared by all channels is scaled by a fine level that each channel owns. The product of the two sets the channel's duty. A mode input replaces this scheme with one 8-bit level that drives every channel to the same duty. This suits uniform dimming of a backlight.

An 8-bit phase counter advances once for each pulse on the prescaled tick input, so one PWM period is 256 ticks. A tick rate near 384 kHz gives a repetition rate of about 1.5 kHz. The level inputs are sampled only when the counter wraps, so a period is never cut short or stretched by a register write. All channels compare against the same counter, so their periods start together. The outputs are active low: a low sink enable turns the LED on.

The level inputs and the tick are plain control pins. They are levels held by the register file and a single-cycle strobe, so there is no stream interface and no back-pressure.

Top module: `pwm_intensity_ctrl`

## Requirements
- R1: While rst_n is low, every sink_n bit is 1. Reset clears the phase counter to 0 and all captured thresholds to 0, so every channel stays off through the first period after reset.
- R2: In two-level mode (unified_en = 0) with a global level G other than 0, channel c gets threshold T = (G+1)*(I+1) - 1. Here I is that channel's fine level, taken from indiv_lvl[4c+3:4c].
- R3: In two-level mode a global level of 0 gives T = 0 on every channel, whatever the fine levels are.
- R4: With unified_en = 1, every channel gets T = unified_lvl, and the global and fine levels have no effect.
- R5: In each period of 256 ticks, a channel drives sink_n low while the counter value is below T. This makes it on for exactly T ticks. A channel with T = 0 is never low.
- R6: A channel with T = 255 stays low for all 256 ticks of every period, with no high pulse at the wrap.
- R7: The counter moves only on a clock where pwm_tick is 1. While pwm_tick stays 0, sink_n holds its value.
- R8: Thresholds are captured only at the wrap, meaning a tick while the counter is 255. Level or mode changes made inside a period take effect only after the next wrap.
- R9: All channels share one counter. On the first output clock of a period, every channel with a nonzero T goes low in the same clock.
- R10: sink_n is registered. It reflects the counter value and thresholds that were present one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_tick | input | 1 | Single-cycle strobe that advances the PWM phase counter |
| global_lvl | input | 4 | Coarse level shared by all channels (two-level mode) |
| indiv_lvl | input | 64 | Fine levels, 4 bits per channel; channel c at bits [4c+3:4c] |
| unified_en | input | 1 | 1 selects the unified 8-bit mode |
| unified_lvl | input | 8 | Threshold applied to every channel in unified mode |
| sink_n | output | 16 | Active-low sink enables, one per channel |

## Verification
A threshold is captured on the same edge as the wrap tick. The sink enable then reflects the counter value and threshold one clock later. The first clock of a new period therefore shows its output on the 257th tick edge after reset, and the bench counts edges from reset release to sample exactly there and just before. For duty checks, the bench holds each setting for 512 ticks so that at least one wrap has captured it. It then counts low samples on each channel over 256 consecutive ticks, which gives the per-period on-count whatever the phase. All outputs are sampled on the falling clock edge, away from the edge where they change.

// File: rtl/pwm_int_pkg.sv
package pwm_int_pkg;
  localparam int unsigned DEF_NCH = 16;
  localparam int unsigned DEF_GW  = 4;
  localparam int unsigned DEF_IW  = 4;

  typedef enum logic {
    MODE_TWO_LEVEL = 1'b0,
    MODE_UNIFIED   = 1'b1
  } pwm_mode_e;
endpackage

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW-1:0] cnt_q;

  assign wrap = tick && (cnt_q == {CW{1'b1}});
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_level_calc.sv
module pwm_level_calc
  import pwm_int_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned GW  = 4,
  parameter int unsigned IW  = 4,
  localparam int unsigned CW = GW + IW,
  localparam int unsigned PW = GW + IW + 2
) (
  input  logic [GW-1:0]      global_lvl,
  input  logic [NCH*IW-1:0]  indiv_lvl,
  input  pwm_mode_e          mode,
  input  logic [CW-1:0]      unified_lvl,
  output logic [NCH*CW-1:0]  thr_next
);
  logic [PW-1:0] g_plus1;
  logic          g_zero;

  assign g_plus1 = PW'(global_lvl) + PW'(1);
  assign g_zero  = (global_lvl == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PW-1:0] i_plus1;
    logic [PW-1:0] prod;
    logic [PW-1:0] prod_m1;
    logic [CW-1:0] thr_c;

    assign i_plus1 = PW'(indiv_lvl[c*IW +: IW]) + PW'(1);
    assign prod    = g_plus1 * i_plus1;
    assign prod_m1 = prod - PW'(1);

    always_comb begin
      if (mode == MODE_UNIFIED) begin
        thr_c = unified_lvl;
      end else if (g_zero) begin
        thr_c = '0;
      end else begin
        thr_c = prod_m1[CW-1:0];
      end
    end

    assign thr_next[c*CW +: CW] = thr_c;
  end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
  parameter int unsigned NCH = 16,
  parameter int unsigned CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCH*CW-1:0] thr_next,
  output logic [NCH*CW-1:0] thr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (load) begin
      thr_q <= thr_next;
    end
  end
endmodule

// File: rtl/pwm_sink_drv.sv
module pwm_sink_drv #(
  parameter int unsigned NCH = 16,
  parameter int unsigned CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cnt,
  input  logic [NCH*CW-1:0] thr_q,
  output logic [NCH-1:0]    sink_n
);
  logic [NCH-1:0] on_vec;

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    logic [CW-1:0] t_c;
    assign t_c       = thr_q[c*CW +: CW];
    assign on_vec[c] = (t_c == {CW{1'b1}}) || (cnt < t_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sink_n <= '1;
    end else begin
      sink_n <= ~on_vec;
    end
  end
endmodule

// File: rtl/pwm_intensity_ctrl.sv
module pwm_intensity_ctrl
  import pwm_int_pkg::*;
#(
  parameter int unsigned NCH = DEF_NCH,
  parameter int unsigned GW  = DEF_GW,
  parameter int unsigned IW  = DEF_IW,
  localparam int unsigned CW = GW + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_tick,
  input  logic [GW-1:0]     global_lvl,
  input  logic [NCH*IW-1:0] indiv_lvl,
  input  logic              unified_en,
  input  logic [CW-1:0]     unified_lvl,
  output logic [NCH-1:0]    sink_n
);
  logic [CW-1:0]     cnt_s;
  logic              wrap_s;
  logic [NCH*CW-1:0] thr_next_s;
  logic [NCH*CW-1:0] thr_q_s;
  pwm_mode_e         mode_s;

  assign mode_s = unified_en ? MODE_UNIFIED : MODE_TWO_LEVEL;

  pwm_phase_ctr #(.CW(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (pwm_tick),
    .cnt   (cnt_s),
    .wrap  (wrap_s)
  );

  pwm_level_calc #(.NCH(NCH), .GW(GW), .IW(IW)) u_calc (
    .global_lvl  (global_lvl),
    .indiv_lvl   (indiv_lvl),
    .mode        (mode_s),
    .unified_lvl (unified_lvl),
    .thr_next    (thr_next_s)
  );

  pwm_shadow_regs #(.NCH(NCH), .CW(CW)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wrap_s),
    .thr_next (thr_next_s),
    .thr_q    (thr_q_s)
  );

  pwm_sink_drv #(.NCH(NCH), .CW(CW)) u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt_s),
    .thr_q  (thr_q_s),
    .sink_n (sink_n)
  );
endmodule

// File: rtl/pwm_intensity_ctrl_chk.sv
module pwm_intensity_ctrl_chk #(
  parameter int unsigned NCH = 16,
  parameter int unsigned GW  = 4,
  parameter int unsigned CW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_tick,
  input logic [GW-1:0]     global_lvl,
  input logic              unified_en,
  input logic [CW-1:0]     unified_lvl,
  input logic [NCH-1:0]    sink_n,
  input logic [CW-1:0]     cnt_s,
  input logic              wrap_s,
  input logic [NCH*CW-1:0] thr_q_s
);
  AST_RESET_OFF: assert property (@(posedge clk)
    !rst_n |=> (sink_n == {NCH{1'b1}})); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_tick |=> (cnt_s == CW'($past(cnt_s) + 1'b1))); // R7

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_tick) ##1 1'b1 |=> $stable(sink_n)); // R7

  AST_THR_WRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_tick && cnt_s == {CW{1'b1}}) |=> $stable(thr_q_s)); // R8

  AST_G0_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_s && !unified_en && global_lvl == '0) |=> (thr_q_s == '0)); // R3

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_UNIFIED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_s && unified_en) |=> (thr_q_s[c*CW +: CW] == $past(unified_lvl))); // R4

    AST_ZERO_NEVER_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q_s[c*CW +: CW] == '0) |=> sink_n[c]); // R5

    AST_FULL_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q_s[c*CW +: CW] == {CW{1'b1}}) |=> !sink_n[c]); // R6
  end
endmodule

bind pwm_intensity_ctrl pwm_intensity_ctrl_chk #(.NCH(NCH), .GW(GW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwm_tick    (pwm_tick),
  .global_lvl  (global_lvl),
  .unified_en  (unified_en),
  .unified_lvl (unified_lvl),
  .sink_n      (sink_n),
  .cnt_s       (cnt_s),
  .wrap_s      (wrap_s),
  .thr_q_s     (thr_q_s)
);

// File: tb/pwm_intensity_ctrl_tb.sv
module pwm_intensity_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int NVEC = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm_tick = 1'b0;
  logic [3:0]    global_lvl = '0;
  logic [63:0]   indiv_lvl = '0;
  logic          unified_en = 1'b0;
  logic [7:0]    unified_lvl = '0;
  logic [15:0]   sink_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_intensity_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_tick    (pwm_tick),
    .global_lvl  (global_lvl),
    .indiv_lvl   (indiv_lvl),
    .unified_en  (unified_en),
    .unified_lvl (unified_lvl),
    .sink_n      (sink_n)
  );

  // vector: {unified_en, unified_lvl[7:0], global[3:0], mul[3:0], add[3:0]}
  // fine level of channel c = (c*mul + add) mod 16
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 8'd0,   4'd15, 4'd1, 4'd0},
    {1'b0, 8'd0,   4'd0,  4'd1, 4'd3},
    {1'b0, 8'd0,   4'd1,  4'd0, 4'd0},
    {1'b0, 8'd0,   4'd7,  4'd3, 4'd5},
    {1'b0, 8'd0,   4'd15, 4'd0, 4'd15},
    {1'b1, 8'd0,   4'd9,  4'd2, 4'd1},
    {1'b1, 8'd255, 4'd0,  4'd1, 4'd0},
    {1'b1, 8'd128, 4'd5,  4'd7, 4'd2},
    {1'b1, 8'd1,   4'd3,  4'd1, 4'd1},
    {1'b0, 8'd0,   4'd10, 4'd5, 4'd9}
  };

  function automatic int fine_of(int c, int mul, int add);
    return (c * mul + add) % 16;
  endfunction

  function automatic int exp_thr(bit uni, int ulvl, int g, int i);
    if (uni) return ulvl;
    if (g == 0) return 0;
    return (g + 1) * (i + 1) - 1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] ref_s;
    cycles(3);
    // R1: reset state
    check(sink_n == 16'hFFFF, "R1", "sink_n in reset", int'(sink_n), 16'hFFFF);

    // Directed: two-level, G=3, all fine=15 -> T=63 on all channels
    global_lvl = 4'd3;
    indiv_lvl  = '1;
    pwm_tick   = 1'b1;
    rst_n      = 1'b1;
    cycles(200);
    check(sink_n == 16'hFFFF, "R8", "off before first wrap (200 ticks)", int'(sink_n), 16'hFFFF);
    cycles(56);
    check(sink_n == 16'hFFFF, "R1", "first period off (256 edges)", int'(sink_n), 16'hFFFF);
    cycles(1);
    check(sink_n == 16'h0000, "R9", "all on at period start", int'(sink_n), 0);

    // mid-period change must not act before wrap
    global_lvl = 4'd0;
    cycles(40);
    check(sink_n == 16'h0000, "R8", "mid-period change ignored", int'(sink_n), 0);
    cycles(21);
    // counter now 62, output reflects 61
    pwm_tick = 1'b0;
    cycles(1);
    ref_s = sink_n;
    cycles(30);
    check(sink_n == ref_s, "R7", "hold without tick stable", int'(sink_n), int'(ref_s));
    check(sink_n == 16'h0000, "R7", "counter frozen at 62 keeps on", int'(sink_n), 0);
    pwm_tick = 1'b1;
    cycles(1);
    check(sink_n == 16'h0000, "R10", "output reflects count 62", int'(sink_n), 0);
    cycles(1);
    check(sink_n == 16'hFFFF, "R5", "off at count 63 with T=63", int'(sink_n), 16'hFFFF);
    cycles(400);
    check(sink_n == 16'hFFFF, "R3", "G=0 after wrap all off", int'(sink_n), 16'hFFFF);

    // Table walk: measure per-period on-count per channel
    for (int v = 0; v < NVEC; v++) begin
      logic [20:0] e;
      int lows [NCH];
      e = VEC[v];
      unified_en  = e[20];
      unified_lvl = e[19:12];
      global_lvl  = e[11:8];
      for (int c = 0; c < NCH; c++) begin
        indiv_lvl[c*4 +: 4] = 4'(fine_of(c, int'(e[7:4]), int'(e[3:0])));
        lows[c] = 0;
      end
      cycles(512);
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        for (int c = 0; c < NCH; c++) if (!sink_n[c]) lows[c]++;
      end
      for (int c = 0; c < NCH; c++) begin
        int t;
        int x;
        string rq;
        t = exp_thr(e[20], int'(e[19:12]), int'(e[11:8]), fine_of(c, int'(e[7:4]), int'(e[3:0])));
        x = (t == 255) ? 256 : t;
        if (e[20]) rq = "R4";
        else if (e[11:8] == 4'd0) rq = "R3";
        else rq = "R2";
        if (t == 255) rq = {rq, "/R6"};
        else rq = {rq, "/R5"};
        check(lows[c] == x, rq, $sformatf("vec %0d ch %0d on-count", v, c), lows[c], x);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule